// File: doc/BRIEF.md
# Static Branch Predictor with Speculation Gate

This block sits beside the decode stage of an in-order pipeline. When a conditional branch reaches decode, it predicts the branch direction from a fixed policy and supplies the next fetch address. It then marks every younger instruction as speculative until the execute stage reports the real outcome. There are three policies. The first always predicts not taken. The second uses the branch direction: a backward branch is predicted taken. The third follows a hint bit that the compiler places in the instruction. The block keeps no history, so a given branch with the same mode always gets the same prediction.

While a branch is unresolved, register-file and memory writes from instructions carrying the speculative tag are blocked. The execute stage reports the outcome. If the prediction was right, the tag clears and the held writes may proceed. If it was wrong, the block pulses a flush one cycle after the outcome arrives, together with the address of the correct path. Only one branch may be in flight at a time. A second branch that reaches decode is stalled until the first one resolves.

Top module: `spec_branch_ctrl`

## Requirements
- R1: After synchronous reset, pred_valid, pred_taken, spec_tag and flush are 0, and next_pc and redirect_pc are 0.
- R2: With policy 0 (or the reserved code 3), an accepted branch is predicted not taken. One cycle after acceptance, pred_valid is 1 and next_pc is dec_pc + INST_BYTES, modulo 2^AW.
- R3: With policy 1, a branch whose target is strictly below its own address is predicted taken, with next_pc = dec_target. A branch whose target is equal or higher is predicted not taken, with next_pc = dec_pc + INST_BYTES.
- R4: With policy 2, dec_hint = 1 predicts taken (next_pc = dec_target) and dec_hint = 0 predicts not taken (next_pc = dec_pc + INST_BYTES).
- R5: spec_tag rises in the cycle after a branch is accepted and stays high until the cycle after exe_resolve.
- R6: On a misprediction, flush is high for exactly one cycle, in the cycle after exe_resolve. In that cycle redirect_pc holds the correct path: dec_target if the branch was taken, otherwise dec_pc + INST_BYTES.
- R7: When the outcome matches the prediction, flush stays 0 and spec_tag clears in the cycle after exe_resolve.
- R8: A branch presented in decode while another branch is unresolved raises dec_stall and is not accepted: pred_valid stays 0. It is accepted once the first branch has resolved.
- R9: rf_we and mem_we follow wb_rf_req and wb_mem_req, except that a request with wb_spec = 1 is blocked while spec_tag or flush is high. Untagged requests always pass.
- R10: exe_resolve with no branch outstanding is ignored: no flush and no change to spec_tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Policy: 0 not-taken, 1 direction, 2 hint, 3 treated as 0 |
| dec_valid | input | 1 | Decode slot holds an instruction |
| dec_is_branch | input | 1 | Decoded instruction is a conditional branch |
| dec_pc | input | AW | Address of the branch |
| dec_target | input | AW | Branch target address |
| dec_hint | input | 1 | Compiler hint bit, 1 = taken |
| dec_stall | output | 1 | Branch held in decode behind an unresolved branch |
| pred_valid | output | 1 | One-cycle pulse: a prediction was made |
| pred_taken | output | 1 | Last predicted direction |
| next_pc | output | AW | Predicted next fetch address |
| spec_tag | output | 1 | Younger instructions are speculative |
| exe_resolve | input | 1 | Execute reports the branch outcome |
| exe_taken | input | 1 | Real branch direction |
| flush | output | 1 | Discard the wrong-path instructions |
| redirect_pc | output | AW | Correct-path fetch address during flush |
| wb_rf_req | input | 1 | Register-file write request |
| wb_mem_req | input | 1 | Memory write request |
| wb_spec | input | 1 | Writing instruction carries the speculative tag |
| rf_we | output | 1 | Gated register-file write enable |
| mem_we | output | 1 | Gated memory write enable |

## Verification
The bench sweeps every policy, every aligned pair of branch address and target in a small address space, both hint values and both outcomes. This covers the equal-address case, where a design using `<=` would wrongly predict taken. It also covers wrap-around of the sequential address, where a wide adder that is not truncated would give a wrong next_pc. On each mispredict the bench checks that flush lands exactly one cycle after the outcome, with the opposite path's address; a design that swapped the two paths would redirect to the predicted path again. Directed cases check the following:
- A second branch is stalled rather than overwriting the saved path.
- A stray outcome while idle does not flush.
- Tagged writes stay blocked during the flush cycle, where a design gating only on spec_tag would leak wrong-path stores.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    POL_NOTTAKEN  = 2'd0,
    POL_DIRECTION = 2'd1,
    POL_HINT      = 2'd2,
    POL_RSVD      = 2'd3
  } policy_e;
endpackage

// File: rtl/sbp_policy.sv
// Combinational static direction choice; no state, so the same inputs always give the same answer.
module sbp_policy #(
  parameter int AW = 32
) (
  input  logic [1:0]    mode,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  input  logic          hint,
  output logic          take
);
  import sbp_pkg::*;
  policy_e pol;
  assign pol = policy_e'(mode);

  always_comb begin
    case (pol)
      POL_DIRECTION: take = (target < pc);   // backward branch -> taken
      POL_HINT:      take = hint;
      default:       take = 1'b0;            // not-taken and reserved code
    endcase
  end
endmodule

// File: rtl/sbp_tracker.sv
// Holds the single in-flight branch, the alternate path and the flush pulse.
module sbp_tracker #(
  parameter int AW         = 32,
  parameter int INST_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_req,
  input  logic          take,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] target,
  input  logic          exe_resolve,
  input  logic          exe_taken,
  output logic          dec_stall,
  output logic          pred_valid,
  output logic          pred_taken,
  output logic [AW-1:0] next_pc,
  output logic          spec_tag,
  output logic          flush,
  output logic [AW-1:0] redirect_pc
);
  localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

  logic          busy_q, flush_q, pvalid_q, ptaken_q;
  logic [AW-1:0] npc_q, alt_q, redir_q;
  logic [AW-1:0] seq_pc;
  logic          accept;

  assign seq_pc    = pc + STEP;
  assign accept    = br_req & ~busy_q & ~flush_q;
  assign dec_stall = br_req & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      flush_q  <= 1'b0;
      pvalid_q <= 1'b0;
      ptaken_q <= 1'b0;
      npc_q    <= '0;
      alt_q    <= '0;
      redir_q  <= '0;
    end else begin
      pvalid_q <= accept;
      flush_q  <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        ptaken_q <= take;
        npc_q    <= take ? target : seq_pc;
        alt_q    <= take ? seq_pc : target;
      end else if (busy_q && exe_resolve) begin
        busy_q <= 1'b0;
        if (exe_taken != ptaken_q) begin
          flush_q <= 1'b1;
          redir_q <= alt_q;
        end
      end
    end
  end

  assign pred_valid  = pvalid_q;
  assign pred_taken  = ptaken_q;
  assign next_pc     = npc_q;
  assign spec_tag    = busy_q;
  assign flush       = flush_q;
  assign redirect_pc = redir_q;

  p_flush_after_resolve_r6: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> $past(busy_q && exe_resolve));
  p_flush_single_r6: assert property (@(posedge clk) disable iff (rst)
    flush_q |=> !flush_q);
  p_tag_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !exe_resolve) |=> busy_q);
  p_idle_no_flush_r10: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> !flush_q);
endmodule

// File: rtl/sbp_write_gate.sv
// Blocks architectural writes from tagged instructions until the branch is confirmed.
module sbp_write_gate (
  input  logic spec_active,
  input  logic wrong_path,
  input  logic wb_rf_req,
  input  logic wb_mem_req,
  input  logic wb_spec,
  output logic rf_we,
  output logic mem_we
);
  logic block;
  assign block  = wb_spec & (spec_active | wrong_path);
  assign rf_we  = wb_rf_req & ~block;
  assign mem_we = wb_mem_req & ~block;
endmodule

// File: rtl/spec_branch_ctrl.sv
module spec_branch_ctrl #(
  parameter int AW         = 32,
  parameter int INST_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          dec_valid,
  input  logic          dec_is_branch,
  input  logic [AW-1:0] dec_pc,
  input  logic [AW-1:0] dec_target,
  input  logic          dec_hint,
  output logic          dec_stall,
  output logic          pred_valid,
  output logic          pred_taken,
  output logic [AW-1:0] next_pc,
  output logic          spec_tag,
  input  logic          exe_resolve,
  input  logic          exe_taken,
  output logic          flush,
  output logic [AW-1:0] redirect_pc,
  input  logic          wb_rf_req,
  input  logic          wb_mem_req,
  input  logic          wb_spec,
  output logic          rf_we,
  output logic          mem_we
);
  logic take;

  sbp_policy #(.AW(AW)) u_policy (
    .mode(mode), .pc(dec_pc), .target(dec_target), .hint(dec_hint), .take(take)
  );

  sbp_tracker #(.AW(AW), .INST_BYTES(INST_BYTES)) u_tracker (
    .clk(clk), .rst(rst), .br_req(dec_valid & dec_is_branch), .take(take),
    .pc(dec_pc), .target(dec_target), .exe_resolve(exe_resolve), .exe_taken(exe_taken),
    .dec_stall(dec_stall), .pred_valid(pred_valid), .pred_taken(pred_taken),
    .next_pc(next_pc), .spec_tag(spec_tag), .flush(flush), .redirect_pc(redirect_pc)
  );

  sbp_write_gate u_gate (
    .spec_active(spec_tag), .wrong_path(flush), .wb_rf_req(wb_rf_req),
    .wb_mem_req(wb_mem_req), .wb_spec(wb_spec), .rf_we(rf_we), .mem_we(mem_we)
  );

  p_tagged_write_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    (wb_spec && spec_tag) |-> !(rf_we || mem_we));
  p_untagged_passes_r9: assert property (@(posedge clk) disable iff (rst)
    (!wb_spec && wb_rf_req) |-> rf_we);
  p_nottaken_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && $past(mode) == 2'd0) |-> !pred_taken);
endmodule

// File: tb/tb_spec_branch_ctrl.sv
module tb_spec_branch_ctrl;
  localparam int AW = 6;
  localparam int IB = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic [1:0] mode = 0;
  logic dec_valid = 0, dec_is_branch = 0, dec_hint = 0;
  logic [AW-1:0] dec_pc = 0, dec_target = 0;
  logic exe_resolve = 0, exe_taken = 0;
  logic wb_rf_req = 0, wb_mem_req = 0, wb_spec = 0;
  logic dec_stall, pred_valid, pred_taken, spec_tag, flush, rf_we, mem_we;
  logic [AW-1:0] next_pc, redirect_pc;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_branch_ctrl #(.AW(AW), .INST_BYTES(IB)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int seqpc(input int pc);
    return (pc + IB) % (1 << AW);
  endfunction

  function automatic int exp_take(input int m, input int pc, input int tg, input int h);
    if (m == 1) return (tg < pc) ? 1 : 0;
    if (m == 2) return h;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 pred_valid", pred_valid, 0);
    chk("R1 pred_taken", pred_taken, 0);
    chk("R1 spec_tag", spec_tag, 0);
    chk("R1 flush", flush, 0);
    chk("R1 next_pc", next_pc, 0);
    chk("R1 redirect_pc", redirect_pc, 0);
    @(negedge clk);

    // R10: stray resolve while idle
    exe_resolve = 1; exe_taken = 1;
    step;
    chk("R10 flush", flush, 0);
    chk("R10 spec_tag", spec_tag, 0);
    chk("R10 pred_valid", pred_valid, 0);
    exe_resolve = 0;
    step;

    // Sweep: R2 R3 R4 R5 R6 R7 R9
    for (int m = 0; m < 4; m++)
      for (int pc = 0; pc < (1 << AW); pc += IB)
        for (int tg = 0; tg < (1 << AW); tg += IB)
          for (int h = 0; h < 2; h++)
            for (int o = 0; o < 2; o++) begin
              int et, mis;
              string rq;
              et = exp_take(m, pc, tg, h);
              mis = (o != et) ? 1 : 0;
              rq = (m == 1) ? "R3" : (m == 2) ? "R4" : "R2";
              mode = 2'(m); dec_pc = AW'(pc); dec_target = AW'(tg); dec_hint = h[0];
              dec_valid = 1; dec_is_branch = 1;
              #1 chk("R8 no stall when idle", dec_stall, 0);
              step;
              chk({rq, " pred_valid"}, pred_valid, 1);
              chk({rq, " pred_taken"}, pred_taken, et);
              chk({rq, " next_pc"}, next_pc, et ? tg : seqpc(pc));
              chk("R5 spec_tag set", spec_tag, 1);
              dec_valid = 0; dec_is_branch = 0;
              wb_rf_req = 1; wb_mem_req = 1; wb_spec = 1;
              #1 chk("R9 rf blocked", rf_we, 0);
              chk("R9 mem blocked", mem_we, 0);
              exe_resolve = 1; exe_taken = o[0];
              step;
              exe_resolve = 0;
              chk("R5 spec_tag clear", spec_tag, 0);
              chk(mis ? "R6 flush" : "R7 no flush", flush, mis);
              if (mis) chk("R6 redirect_pc", redirect_pc, o ? tg : seqpc(pc));
              chk("R9 rf after resolve", rf_we, mis ? 0 : 1);
              step;
              chk("R6 flush one cycle", flush, 0);
              chk("R9 rf confirmed", rf_we, 1);
              chk("R9 mem confirmed", mem_we, 1);
              wb_rf_req = 0; wb_mem_req = 0; wb_spec = 0;
            end

    // R8: second branch stalls
    mode = 0; dec_pc = 8; dec_target = 0; dec_valid = 1; dec_is_branch = 1;
    step;
    chk("R8 first accepted", pred_valid, 1);
    dec_pc = 20; dec_target = 40;
    #1 chk("R8 stall", dec_stall, 1);
    // R9 untagged write passes during speculation
    wb_rf_req = 1; wb_spec = 0;
    #1 chk("R9 untagged passes", rf_we, 1);
    wb_rf_req = 0;
    step;
    chk("R8 not accepted", pred_valid, 0);
    chk("R8 still tagged", spec_tag, 1);
    exe_resolve = 1; exe_taken = 0;
    step;
    exe_resolve = 0;
    chk("R8 not accepted at resolve", pred_valid, 0);
    chk("R7 no flush", flush, 0);
    #1 chk("R8 stall released", dec_stall, 0);
    step;
    chk("R8 second accepted", pred_valid, 1);
    chk("R8 second next_pc", next_pc, 24);
    dec_valid = 0; dec_is_branch = 0;
    exe_resolve = 1; exe_taken = 1;
    step;
    exe_resolve = 0;
    chk("R6 flush second", flush, 1);
    chk("R6 redirect second", redirect_pc, 40);
    step;

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule